// File: doc/BRIEF.md
# Idle-Line Multiprocessor Serial Receiver

This block is an asynchronous serial receiver for a shared line where one talker addresses many listeners. The line is sampled on a 16x oversampling tick and each character is built from a start bit, a configurable number of data bits sent least significant bit first, an optional parity bit and a stop bit. Between characters the receiver times how long the line stays at mark. A long enough quiet stretch marks the next character as an address character, and the receiver stores that tag next to the character in the receive buffer.

A host-owned wake filter input lets a listener skip traffic that is not meant for it. While the filter is on, every character is still framed, but only address characters are written to the buffer, update the error flags and raise the receive flag. Software reads the address, compares it with its own, and turns the filter off to take the data that follows. The receiver never changes the filter input itself. A one-cycle read strobe takes a character out of the buffer.

Top module: `mpidle_uart_rx`

## Requirements
- R1: After reset, rx_flag, err_overrun, err_frame, err_parity and rx_addr_tag are 0, rx_data is 0, and the line counts as idle, so the first character received is tagged as an address character.
- R2: A falling edge on the line starts a character only if the line is still low at the middle of the start bit. A shorter low pulse is dropped: it delivers nothing and changes no output. Data bits arrive least significant bit first.
- R3: When the line stays at mark for 10 or more bit times, counted from the end of the first stop bit, the next character is tagged as an address (rx_addr_tag = 1). A shorter gap gives rx_addr_tag = 0. Each character uses up the idle condition.
- R4: In a frame with two stop bits, the second stop bit counts toward the idle period. A gap of 9.5 bit times after two stop bits therefore produces an address character, and the same gap after one stop bit does not.
- R5: While wake_en = 1, a character that is not an address character leaves rx_data, rx_addr_tag, rx_flag, err_frame, err_parity and err_overrun unchanged.
- R6: While wake_en = 1, an address character is written to rx_data with rx_addr_tag = 1 and sets rx_flag. While wake_en = 0, every character is delivered.
- R7: A one-cycle pulse on rd_stb clears rx_flag and err_overrun.
- R8: When a character is delivered while rx_flag is still 1 and is not being read in the same cycle, err_overrun goes to 1 and the new character replaces the old one.
- R9: With par_en = 1, the expected parity bit is the XOR of the data bits XOR par_odd. A mismatch sets err_parity. A stop bit sampled low sets err_frame. Both flags are loaded for each delivered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_in | input | 1 | Serial line, mark = 1 |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| wake_en | input | 1 | Host-owned filter: deliver only address characters |
| rd_stb | input | 1 | One-cycle read of the receive buffer |
| rx_data | output | DATA_W | Receive buffer |
| rx_addr_tag | output | 1 | Buffered character was an address character |
| rx_flag | output | 1 | Receive flag, set on delivery |
| err_frame | output | 1 | Stop bit was low on the buffered character |
| err_parity | output | 1 | Parity mismatch on the buffered character |
| err_overrun | output | 1 | A delivery overwrote an unread character |

## Verification
The assertions assume that rd_stb is a single-cycle pulse and that par_en, par_odd and the stop-bit count do not change while a character is on the line. The stimulus changes configuration only in the gaps between characters. Gap lengths are kept clear of a band around the 10-bit-time threshold, so the expected tag does not depend on a tick or two of synchronizer delay. A framing error is always followed by at least two bit times of mark, so the next start edge can be seen.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } rx_state_e;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_n;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mpr_framer.sv
module mpr_framer
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              in_hunt,
  output logic              frame_done,
  output logic [DATA_W-1:0] word,
  output logic              perr,
  output logic              ferr
);
  localparam int CW    = $clog2(OVS);
  localparam int BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID   = OVS / 2 - 1;
  localparam int LAST  = OVS - 1;
  localparam int TAILN = OVS / 2 - 1;

  rx_state_e         state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic [DATA_W-1:0] shf_q, shf_n;
  logic              parb_q, parb_n;
  logic              prev_q, prev_n;
  logic              fall;

  assign fall = tick && prev_q && !rx_s;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    shf_n   = shf_q;
    parb_n  = parb_q;
    prev_n  = tick ? rx_s : prev_q;
    case (state_q)
      ST_HUNT: begin
        if (fall) begin
          state_n = ST_START;
          cnt_n   = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == CW'(MID)) begin
            cnt_n   = '0;
            bit_n   = '0;
            state_n = rx_s ? ST_HUNT : ST_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (cnt_q == CW'(LAST)) begin
            cnt_n = '0;
            shf_n = {rx_s, shf_q[DATA_W-1:1]};
            if (bit_q == BW'(DATA_W - 1)) state_n = par_en ? ST_PAR : ST_STOP;
            else                          bit_n   = bit_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (tick) begin
          if (cnt_q == CW'(LAST)) begin
            cnt_n   = '0;
            parb_n  = rx_s;
            state_n = ST_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (cnt_q == CW'(LAST)) begin
            cnt_n   = '0;
            state_n = ST_TAIL;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (fall) begin
          cnt_n   = '0;
          state_n = ST_START;
        end else if (tick) begin
          if (cnt_q == CW'(TAILN - 1)) state_n = ST_HUNT;
          else                         cnt_n   = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      parb_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      shf_q   <= shf_n;
      parb_q  <= parb_n;
      prev_q  <= prev_n;
    end
  end

  assign in_hunt    = (state_q == ST_HUNT);
  assign frame_done = tick && (state_q == ST_STOP) && (cnt_q == CW'(LAST));
  assign word       = shf_q;
  assign perr       = par_en && (parb_q != ((^shf_q) ^ par_odd));
  assign ferr       = !rx_s;
endmodule

// File: rtl/mpr_idle.sv
module mpr_idle #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic in_hunt,
  input  logic frame_done,
  output logic idle_seen
);
  localparam int THR = IDLE_BITS * OVS;
  localparam int W   = $clog2(THR + 1);

  logic [W-1:0] cnt_q, cnt_n;
  logic         seen_q, seen_n;

  always_comb begin
    cnt_n  = cnt_q;
    seen_n = seen_q;
    if (!in_hunt) begin
      cnt_n = '0;
    end else if (tick) begin
      if (!rx_s)                cnt_n = '0;
      else if (cnt_q != W'(THR)) cnt_n = cnt_q + 1'b1;
    end
    if (frame_done)
      seen_n = 1'b0;
    else if (in_hunt && tick && rx_s && (cnt_q == W'(THR - 1)))
      seen_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
    end
  end

  assign idle_seen = seen_q;
endmodule

// File: rtl/mpr_rxbuf.sv
module mpr_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              is_addr,
  input  logic [DATA_W-1:0] word,
  input  logic              perr,
  input  logic              ferr,
  input  logic              wake_en,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] data_o,
  output logic              tag_o,
  output logic              flag_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q, data_n;
  logic tag_q, tag_n, flag_q, flag_n, fe_q, fe_n, pe_q, pe_n, ovr_q, ovr_n;
  logic deliver;

  always_comb begin
    deliver = frame_done && (!wake_en || is_addr);
    data_n  = data_q;
    tag_n   = tag_q;
    flag_n  = flag_q;
    fe_n    = fe_q;
    pe_n    = pe_q;
    ovr_n   = ovr_q;
    if (deliver) begin
      data_n = word;
      tag_n  = is_addr;
      fe_n   = ferr;
      pe_n   = perr;
      flag_n = 1'b1;
      ovr_n  = (ovr_q | flag_q) & ~rd_stb;
    end else if (rd_stb) begin
      flag_n = 1'b0;
      ovr_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= 1'b0;
      flag_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      tag_q  <= tag_n;
      flag_q <= flag_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
      ovr_q  <= ovr_n;
    end
  end

  assign data_o = data_q;
  assign tag_o  = tag_q;
  assign flag_o = flag_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/mpidle_uart_rx.sv
module mpidle_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wake_en,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr_tag,
  output logic              rx_flag,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic              rx_s;
  logic              in_hunt;
  logic              frame_done;
  logic              idle_seen;
  logic [DATA_W-1:0] word;
  logic              perr;
  logic              ferr;

  mpr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  mpr_framer #(.DATA_W(DATA_W), .OVS(OVS)) framer_i (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .par_en(par_en), .par_odd(par_odd), .in_hunt(in_hunt),
    .frame_done(frame_done), .word(word), .perr(perr), .ferr(ferr)
  );

  mpr_idle #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) idle_i (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .in_hunt(in_hunt), .frame_done(frame_done), .idle_seen(idle_seen)
  );

  mpr_rxbuf #(.DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .is_addr(idle_seen),
    .word(word), .perr(perr), .ferr(ferr), .wake_en(wake_en), .rd_stb(rd_stb),
    .data_o(rx_data), .tag_o(rx_addr_tag), .flag_o(rx_flag),
    .fe_o(err_frame), .pe_o(err_parity), .ovr_o(err_overrun)
  );
endmodule

// File: rtl/mpidle_uart_rx_chk.sv
module mpidle_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              wake_en,
  input logic              frame_done,
  input logic              idle_seen,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_addr_tag,
  input logic              rx_flag,
  input logic              err_frame,
  input logic              err_parity,
  input logic              err_overrun
);
  AST_IDLE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !idle_seen); // R3

  AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && wake_en && !idle_seen |=>
      $stable(rx_data) && $stable(rx_addr_tag) && $stable(err_frame) && $stable(err_parity)); // R5

  AST_ADDR_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && idle_seen |=> rx_flag && rx_addr_tag); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !frame_done |=> !rx_flag && !err_overrun); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (!wake_en || idle_seen) && rx_flag && !rd_stb |=> err_overrun); // R8
endmodule

bind mpidle_uart_rx mpidle_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wake_en(wake_en),
  .frame_done(frame_done), .idle_seen(idle_seen), .rx_data(rx_data),
  .rx_addr_tag(rx_addr_tag), .rx_flag(rx_flag), .err_frame(err_frame),
  .err_parity(err_parity), .err_overrun(err_overrun)
);

// File: tb/mpidle_uart_rx_tb.sv
module mpidle_uart_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int OVS        = 16;
  localparam int DW         = 8;
  localparam int IDLE_BITS  = 10;
  localparam int BITCLK     = OVS * TDIV;
  localparam int THR        = IDLE_BITS * OVS;

  logic clk, rst_n, os_tick, rx_in, par_en, par_odd, wake_en, rd_stb;
  logic [DW-1:0] rx_data;
  logic rx_addr_tag, rx_flag, err_frame, err_parity, err_overrun;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [DW-1:0] m_data;
  bit m_tag, m_flag, m_fe, m_pe, m_ovr, m_idle;

  mpidle_uart_rx #(.DATA_W(DW), .OVS(OVS), .IDLE_BITS(IDLE_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .par_en(par_en), .par_odd(par_odd), .wake_en(wake_en), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_addr_tag(rx_addr_tag), .rx_flag(rx_flag),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        os_tick = (i == TDIV - 1);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit par_bit(input logic [DW-1:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  function automatic bit gap_is_idle(input int gap_ticks, input bit two_stop);
    return (gap_ticks + (two_stop ? OVS : 0)) >= THR;
  endfunction

  task automatic check_buf(input string req);
    chk(req, "rx_data", int'(rx_data), int'(m_data));
    chk("R3", "rx_addr_tag", int'(rx_addr_tag), int'(m_tag));
    chk(req, "rx_flag", int'(rx_flag), int'(m_flag));
    chk("R9", "err_frame", int'(err_frame), int'(m_fe));
    chk("R9", "err_parity", int'(err_parity), int'(m_pe));
    chk("R8", "err_overrun", int'(err_overrun), int'(m_ovr));
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    wait_clk(1);
    rd_stb = 1'b0;
    m_flag = 1'b0;
    m_ovr  = 1'b0;
    chk("R7", "rx_flag after read", int'(rx_flag), 0);
    chk("R7", "err_overrun after read", int'(err_overrun), 0);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input bit bad_par, input bit bad_stop,
                            input bit two_stop, input int gap_ticks, input bit rd);
    bit addr, deliver;
    string req;
    addr   = m_idle;
    m_idle = 1'b0;
    rx_in = 1'b0; wait_clk(BITCLK);
    for (int i = 0; i < DW; i++) begin
      rx_in = d[i]; wait_clk(BITCLK);
    end
    if (par_en) begin
      rx_in = par_bit(d, par_odd) ^ bad_par; wait_clk(BITCLK);
    end
    rx_in = !bad_stop; wait_clk(BITCLK);
    if (two_stop) begin
      rx_in = 1'b1; wait_clk(BITCLK);
    end
    rx_in = 1'b1;
    deliver = !wake_en || addr;
    if (deliver) begin
      m_ovr  = m_ovr | m_flag;
      m_flag = 1'b1;
      m_data = d;
      m_tag  = addr;
      m_fe   = bad_stop;
      m_pe   = par_en && bad_par;
    end
    if (!deliver)     req = "R5";
    else if (wake_en) req = "R6";
    else              req = "R2";
    check_buf(req);
    if (rd) do_read();
    wait_clk(gap_ticks * TDIV);
    if (gap_is_idle(gap_ticks, two_stop)) m_idle = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rx_in = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    wake_en = 1'b1; rd_stb = 1'b0;
    m_data = '0; m_tag = 0; m_flag = 0; m_fe = 0; m_pe = 0; m_ovr = 0; m_idle = 1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    chk("R1", "rx_flag at reset", int'(rx_flag), 0);
    chk("R1", "err_overrun at reset", int'(err_overrun), 0);
    chk("R1", "err_frame at reset", int'(err_frame), 0);
    chk("R1", "err_parity at reset", int'(err_parity), 0);
    chk("R1", "rx_data at reset", int'(rx_data), 0);
    wait_clk(BITCLK * 2);

    // R1/R6: first character after reset is an address, delivered through the filter
    send_frame(8'hA5, 0, 0, 0, 4 * OVS, 1);
    chk("R1", "first char tagged address", int'(m_tag), 1);
    // R5: short gap -> data character suppressed by the filter
    send_frame(8'h3C, 0, 0, 0, 12 * OVS, 0);
    // R3/R6: long gap -> address character delivered
    send_frame(8'h5A, 0, 0, 0, 2 * OVS, 0);
    chk("R6", "address tag under filter", int'(rx_addr_tag), 1);
    do_read();

    // R3 boundary pair, filter off
    wake_en = 1'b0;
    send_frame(8'h11, 0, 0, 0, 9 * OVS, 1);
    send_frame(8'h22, 0, 0, 0, 11 * OVS, 1);
    chk("R3", "9-bit gap gives data", int'(m_tag), 0);
    send_frame(8'h33, 0, 0, 0, 2 * OVS, 1);
    chk("R3", "11-bit gap gives address", int'(rx_addr_tag), 1);

    // R4: 9.5 bit gap after one vs two stop bits
    send_frame(8'h44, 0, 0, 0, 152, 1);
    send_frame(8'h55, 0, 0, 1, 152, 1);
    chk("R4", "one stop + 9.5 bits is not idle", int'(m_tag), 0);
    send_frame(8'h66, 0, 0, 0, 3 * OVS, 1);
    chk("R4", "two stops + 9.5 bits is idle", int'(rx_addr_tag), 1);

    // R2: start glitch is rejected
    wait_clk(12 * BITCLK);
    m_idle = 1'b1;
    rx_in = 1'b0; wait_clk(3 * TDIV); rx_in = 1'b1;
    wait_clk(2 * BITCLK);
    chk("R2", "glitch gives no flag", int'(rx_flag), 0);
    chk("R2", "glitch leaves data", int'(rx_data), 8'h66);
    send_frame(8'h81, 0, 0, 0, 2 * OVS, 1);

    // R8: overrun, then R7 read clears
    send_frame(8'h01, 0, 0, 0, 2 * OVS, 0);
    send_frame(8'h02, 0, 0, 0, 2 * OVS, 0);
    chk("R8", "overrun on unread buffer", int'(err_overrun), 1);
    do_read();

    // R9: parity and framing errors
    par_en = 1'b1; par_odd = 1'b1;
    send_frame(8'h7E, 1, 0, 0, 2 * OVS, 1);
    send_frame(8'h7E, 0, 1, 0, 3 * OVS, 1);
    par_odd = 1'b0;
    send_frame(8'hC3, 0, 0, 1, 2 * OVS, 1);

    // Random traffic
    for (int n = 0; n < 60; n++) begin
      bit bp, bs, ts, rdn;
      int gap;
      wake_en = ($urandom % 3) == 0;
      par_en  = $urandom % 2;
      par_odd = $urandom % 2;
      bp  = ($urandom % 8) == 0;
      bs  = ($urandom % 8) == 0;
      ts  = $urandom % 2;
      rdn = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) gap = 176 + ($urandom % 64);
      else                   gap = $urandom % 129;
      if (bs && gap < 2 * OVS) gap = 2 * OVS;
      send_frame(8'($urandom), bp, bs, ts, gap, rdn);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule